// File: doc/BRIEF.md
# Two-Stage Integer Clock Divider with Coarse Phase Stepping

This block divides a fast source clock by the product of a small prescaler (4, 5 or 6) and an even second-stage ratio, or by the prescaler alone when the second stage is bypassed. The result is one divided clock output, which can be inverted to give a half-period shift.

The output phase can be moved later in whole source-clock steps. Software sets a step count and toggles a trigger input. The block then lengthens one output period by a single source cycle and repeats this every fourth output period until the whole count has been applied. A busy flag covers the request while it runs. A resync pulse discards any pending steps and restarts both counter stages from zero, so that dividers with identical settings released by the same pulse stay edge-aligned.

Top module: `int_out_divider`

## Requirements
- R1: The prescaler select picks the first-stage ratio: code 0 gives 4, code 1 gives 5, and codes 2 and 3 give 6.
- R2: An even second-stage ratio r with r of at least 2 multiplies the output period by r. A ratio of 0 or any odd value bypasses the second stage (divide by 1). The output period equals the prescaler ratio times the effective second-stage ratio.
- R3: With invert clear, each output period starts with a high phase of floor(N/2) source cycles and ends with a low phase, where N is the total ratio. For even N this gives a 50% duty cycle.
- R4: With invert set, the output is the complement of the non-inverted output: it keeps the same period and has a high time of N - floor(N/2).
- R5: A request for k steps adds one source cycle to the output period in progress when the request is taken. It then adds one cycle to every fourth period after that, until k periods have been lengthened. All other periods keep length N.
- R6: Up to 31 steps can be requested at once. Busy is high from the cycle after an accepted toggle until the last extra cycle is inserted, and low otherwise.
- R7: A trigger toggle that arrives while busy is high is ignored. Only the steps of the running request are applied.
- R8: A resync pulse clears pending steps and drops busy. It holds both counters at zero, so the output is in the first (high) phase in the cycle after the resync edge. The period that follows has length N.
- R9: A request for zero steps leaves busy low and leaves every period at length N.
- R10: After reset, busy is low and both counters start from zero, so the non-inverted output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | First-stage ratio select |
| ratio | input | RATIO_W | Second-stage ratio; 0 or odd selects bypass |
| invert | input | 1 | Inverts the divided output |
| steps | input | STEP_W | Number of one-cycle phase steps for the next request |
| trig | input | 1 | Request trigger, acts on each toggle |
| resync | input | 1 | Synchronous restart of the counters; clears pending steps |
| busy | output | 1 | High while phase steps remain to be applied |
| clk_out | output | 1 | Divided clock output |

## Verification
The bench builds the block with RATIO_W = 6, which limits the second stage to ratios up to 62. At that width every even ratio, together with zero and several odd bypass values, can be swept against every prescaler code, so that the full period and duty table is measured. STEP_W stays at 5, so a full 31-step request runs to completion, and its stretched periods can be counted individually against the every-fourth-period pattern. Ignored toggles, resync during a request and zero-step requests are each checked on the periods that follow.

// File: rtl/int_out_divider.sv
module int_out_divider #(
  parameter int RATIO_W = 17,
  parameter int STEP_W  = 5,
  parameter int GAP     = 4
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [1:0]         pre_sel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               invert,
  input  logic [STEP_W-1:0]  steps,
  input  logic               trig,
  input  logic               resync,
  output logic               busy,
  output logic               clk_out
);
  localparam int GAP_W = (GAP > 2) ? $clog2(GAP) : 1;
  localparam logic [RATIO_W-1:0] ONE_R = {{(RATIO_W-1){1'b0}}, 1'b1};

  logic [2:0]         pdiv, half_p, pre_cnt;
  logic [RATIO_W-1:0] sec_cnt;
  logic [STEP_W-1:0]  rem;
  logic [GAP_W-1:0]   gap;
  logic               stalled, trig_q;
  logic               bypass, pre_last, sec_last, at_last, stall_now, toggle, raw;

  assign pdiv      = (pre_sel == 2'd0) ? 3'd4 : (pre_sel == 2'd1) ? 3'd5 : 3'd6;
  assign half_p    = pdiv >> 1;
  assign bypass    = (ratio < 2) || ratio[0];
  assign pre_last  = pre_cnt >= (pdiv - 3'd1);
  assign sec_last  = bypass || (sec_cnt >= (ratio - ONE_R));
  assign at_last   = pre_last && sec_last;
  assign busy      = rem != '0;
  assign stall_now = at_last && busy && (gap == '0) && !stalled;
  assign toggle    = trig ^ trig_q;
  assign raw       = bypass ? (pre_cnt < half_p) : (sec_cnt < (ratio >> 1));
  assign clk_out   = raw ^ invert;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      sec_cnt <= '0;
      rem     <= '0;
      gap     <= '0;
      stalled <= 1'b0;
      trig_q  <= 1'b0;
    end else if (resync) begin
      pre_cnt <= '0;
      sec_cnt <= '0;
      rem     <= '0;
      gap     <= '0;
      stalled <= 1'b0;
      trig_q  <= trig;
    end else begin
      trig_q  <= trig;
      stalled <= stall_now;
      if (!stall_now) begin
        if (pre_last) begin
          pre_cnt <= '0;
          sec_cnt <= sec_last ? '0 : sec_cnt + ONE_R;
        end else begin
          pre_cnt <= pre_cnt + 3'd1;
        end
      end
      if (stall_now) begin
        rem <= rem - 1'b1;
        gap <= GAP_W'(GAP - 1);
      end else if (at_last && !stalled && gap != '0) begin
        gap <= gap - 1'b1;
      end
      if (toggle && !busy) begin
        rem <= steps;
        gap <= '0;
      end
    end
  end

  a_r1_pre_bound: assert property (@(posedge clk_src) disable iff (!rst_n)
    ($stable(pre_sel) && !resync && pre_cnt < pdiv) |=> pre_cnt < pdiv);

  a_r5_single_extra: assert property (@(posedge clk_src) disable iff (!rst_n)
    (stall_now && !resync) |=> (!stall_now && $stable(pre_cnt) && $stable(sec_cnt)));

  a_r6_busy_fall: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(busy) |-> $past(stall_now || resync));

  a_r7_ignore_toggle: assert property (@(posedge clk_src) disable iff (!rst_n)
    (busy && toggle && !resync) |=> rem <= $past(rem));

  a_r8_resync_clear: assert property (@(posedge clk_src) disable iff (!rst_n)
    resync |=> (pre_cnt == '0 && sec_cnt == '0 && !busy));

  a_r9_zero_request: assert property (@(posedge clk_src) disable iff (!rst_n)
    (toggle && !busy && !resync && steps == '0) |=> !busy);
endmodule

// File: tb/int_out_divider_tb.sv
module int_out_divider_tb;
  localparam int RW = 6;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [RW-1:0] ratio = RW'(2);
  logic invert = 1'b0;
  logic [SW-1:0] steps = '0;
  logic trig = 1'b0;
  logic resync = 1'b0;
  logic busy, clk_out;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  int_out_divider #(.RATIO_W(RW), .STEP_W(SW), .GAP(4)) u_dut (
    .clk_src(clk), .rst_n(rst_n), .pre_sel(pre_sel), .ratio(ratio),
    .invert(invert), .steps(steps), .trig(trig), .resync(resync),
    .busy(busy), .clk_out(clk_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_period(output int len, output int hi);
    logic p;
    len = 0; hi = 0;
    do begin
      if (clk_out) hi++;
      p = clk_out;
      len++;
      @(negedge clk);
    end while (p || !clk_out);
  endtask

  task automatic sync_rise();
    logic p;
    do begin
      p = clk_out;
      @(negedge clk);
    end while (p || !clk_out);
  endtask

  task automatic set_cfg(input int ps, input int r, input bit inv);
    @(negedge clk);
    pre_sel = 2'(ps); ratio = RW'(r); invert = inv; resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
  endtask

  function automatic int total(input int ps, input int r);
    int pd, rr;
    pd = (ps == 0) ? 4 : (ps == 1) ? 5 : 6;
    rr = (r < 2 || (r % 2) == 1) ? 1 : r;
    return pd * rr;
  endfunction

  task automatic phase_run(input int k, input int nper, input int n, input bit late_toggle);
    int len, hi, exp;
    sync_rise();
    chk(busy == 1'b0, "R6 idle before request", busy, 0);
    steps = SW'(k); trig = ~trig;
    for (int j = 0; j < nper; j++) begin
      get_period(len, hi);
      exp = ((j % 4) == 0 && (j / 4) < k) ? n + 1 : n;
      chk(len == exp, late_toggle ? "R7 period after ignored toggle" : "R5 stepped period", len, exp);
      if (j == 0) begin
        chk(busy == (k > 1), "R6 busy after first step", busy, (k > 1));
        if (late_toggle) begin
          steps = SW'(5); trig = ~trig;
        end
      end
    end
    chk(busy == 1'b0, "R6 busy low after request", busy, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int len, hi, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy after reset", busy, 0);
    chk(clk_out == 1'b1, "R10 output after reset", clk_out, 1);

    // R1 R2 R3: sweep prescaler codes against even and bypass ratios
    for (int ps = 0; ps < 4; ps++) begin
      for (int r = 0; r < 64; r++) begin
        if ((r % 2) == 0 || r == 1 || r == 3 || r == 63) begin
          set_cfg(ps, r, 1'b0);
          n = total(ps, r);
          chk(clk_out == 1'b1, "R8 high after resync", clk_out, 1);
          get_period(len, hi);
          chk(len == n, "R1 R2 period", len, n);
          chk(hi == n / 2, "R3 high time", hi, n / 2);
        end
      end
    end

    // R4: inverted output
    for (int ps = 0; ps < 3; ps++) begin
      for (int r = 0; r < 8; r += 3) begin
        set_cfg(ps, r, 1'b1);
        n = total(ps, r);
        chk(clk_out == 1'b0, "R4 inverted first phase", clk_out, 0);
        sync_rise();
        get_period(len, hi);
        chk(len == n, "R4 inverted period", len, n);
        chk(hi == n - n / 2, "R4 inverted high time", hi, n - n / 2);
      end
    end

    // R5 R6: stepping
    set_cfg(0, 2, 1'b0);
    phase_run(1, 6, 8, 1'b0);
    phase_run(3, 14, 8, 1'b0);
    phase_run(31, 128, 8, 1'b0);
    set_cfg(1, 0, 1'b0);
    phase_run(2, 10, 5, 1'b0);

    // R7: toggle during busy ignored
    set_cfg(2, 4, 1'b0);
    phase_run(2, 14, 24, 1'b1);

    // R9: zero-step request
    set_cfg(0, 6, 1'b0);
    sync_rise();
    steps = '0; trig = ~trig;
    @(negedge clk);
    chk(busy == 1'b0, "R9 busy stays low", busy, 0);
    for (int j = 0; j < 5; j++) begin
      if (j == 0) sync_rise();
      get_period(len, hi);
      chk(len == 24, "R9 period unchanged", len, 24);
    end

    // R8: resync during a request
    set_cfg(0, 2, 1'b0);
    sync_rise();
    steps = SW'(5); trig = ~trig;
    @(negedge clk);
    chk(busy == 1'b1, "R6 busy after toggle", busy, 1);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    chk(busy == 1'b0, "R8 busy cleared", busy, 0);
    chk(clk_out == 1'b1, "R8 output restarted", clk_out, 1);
    for (int j = 0; j < 6; j++) begin
      get_period(len, hi);
      chk(len == 8, "R8 no pending steps", len, 8);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule